// File: doc/BRIEF.md
# Pipelined 3x3 Colour Matrix Converter with Input Offsets

The block turns a stream of three-component pixels, typically luma plus two chroma samples, into RGB. It adds a signed offset to each incoming component and multiplies the three offset components by one row of a 3x3 coefficient matrix. It sums the products, adds a per-row constant, rounds, and clamps the result to the sample range. One pixel can enter on every clock. The result appears a fixed three cycles later. There is no backpressure.

Software loads twelve 32-bit words through a simple write port. Each of the three matrix rows holds three multiplier words followed by one word that packs an input offset and an output constant. A thirteenth location holds a two-bit control word: one bit enables the conversion and the other exchanges the two chroma columns. This lets an input stream with the chroma samples in the reverse order use an unchanged table.

All writes land in a shadow copy. A frame-start pulse copies the shadow copy into the working set, so a frame is always converted with one coefficient set. With the enable bit clear, the block passes the pixels through unchanged, still with three cycles of delay.

Top module: `ycc_mtx_conv`

## Requirements
- R1: While reset is high and on the first cycle after it, `pix_out_vld` is 0. Reset clears every shadow and working word and both control bits, so the block starts in pass-through.
- R2: With the working control bit 0 (enable) set, output k equals floor((ck0*(a0+d0) + ck1*(a1+d1) + ck2*(a2+d2) + constk*2^17 + 2^16) / 2^17). Multiplier word ckj sits at location 4k+j and is two's complement with 17 fractional bits, so 0x00020000 means 1.0.
- R3: Each converted output is clamped: a negative result gives 0 and a result above 1023 gives 1023.
- R4: In the word at location 4k+3, bits [31:16] hold the signed offset dk, which is added to input component k in every row. Bits [15:0] hold the signed constant constk for output k, in output sample units.
- R5: With the working control bit 1 (swap) set, the multiplier at location 4k+1 applies to input 2 and the one at 4k+2 applies to input 1, in every row. The offsets stay with their input index.
- R6: With the working enable bit clear, outputs 0, 1 and 2 equal inputs 0, 1 and 2 unchanged, whatever the swap bit holds.
- R7: A pixel presented with `pix_in_vld` high appears with `pix_out_vld` high exactly 3 cycles later. A cycle with `pix_in_vld` low gives a cycle with `pix_out_vld` low 3 cycles later.
- R8: Writes change only the shadow set. The working set, including the control word, takes the shadow contents only on a cycle with `frame_sof` high. A pixel presented in that same cycle already uses the new set. A write in that same cycle is not part of the copy.
- R9: Write locations 0 to 11 are coefficient words and location 12 is the control word (bit 0 enable, bit 1 swap). Writes to locations 13 to 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the shadow set |
| cfg_sel | input | 4 | Write location |
| cfg_data | input | 32 | Write data |
| frame_sof | input | 1 | Frame-start pulse; copies the shadow set into the working set |
| pix_in_vld | input | 1 | Input pixel valid |
| pix_in0 | input | 10 | Input component 0 (luma) |
| pix_in1 | input | 10 | Input component 1 (first chroma) |
| pix_in2 | input | 10 | Input component 2 (second chroma) |
| pix_out_vld | output | 1 | Output pixel valid |
| pix_out0 | output | 10 | Output component 0 (red) |
| pix_out1 | output | 10 | Output component 1 (green) |
| pix_out2 | output | 10 | Output component 2 (blue) |

## Verification
Three things can fall on one clock: a frame-start copy, a shadow write and a pixel entering the pipeline. The bench forces all three together, both on purpose and through a random phase with gaps in valid, random writes and random frame starts. A frame-start cycle must convert its own pixel with the newly copied set. The write made in that same cycle must reach the working set only at the next frame start. The behavioural model applies these rules in that order and compares every output cycle against them, so a pixel converted with the old set, or a write that slips into the copy early, shows up as a miscompare.

// File: rtl/ycc_mtx_pkg.sv
`timescale 1ns/1ps
package ycc_mtx_pkg;
  localparam int NCOMP = 3;
  localparam int WPR   = NCOMP + 1;
  localparam int NWORD = NCOMP * WPR;

  typedef struct packed {
    logic swap;
    logic en;
  } ctrl_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ycc_mtx_regs.sv
`timescale 1ns/1ps
module ycc_mtx_regs
  import ycc_mtx_pkg::*;
#(
  parameter int COEF_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cfg_wr,
  input  logic [ADDR_W-1:0]              cfg_sel,
  input  logic [COEF_W-1:0]              cfg_data,
  input  logic                           frame_sof,
  output logic [NWORD-1:0][COEF_W-1:0]   shd_w,
  output logic [NWORD-1:0][COEF_W-1:0]   act_w,
  output ctrl_t                          shd_ctrl,
  output ctrl_t                          act_ctrl
);
  localparam logic [ADDR_W-1:0] CTRL_SEL = ADDR_W'(NWORD);

  always_ff @(posedge clk) begin
    if (rst) begin
      shd_w    <= '0;
      act_w    <= '0;
      shd_ctrl <= '0;
      act_ctrl <= '0;
    end else begin
      if (frame_sof) begin
        act_w    <= shd_w;
        act_ctrl <= shd_ctrl;
      end
      if (cfg_wr) begin
        for (int w = 0; w < NWORD; w++) begin
          if (cfg_sel == ADDR_W'(w)) shd_w[w] <= cfg_data;
        end
        if (cfg_sel == CTRL_SEL) shd_ctrl <= ctrl_t'(cfg_data[1:0]);
      end
    end
  end
endmodule

// File: rtl/ycc_mtx_row.sv
`timescale 1ns/1ps
module ycc_mtx_row
  import ycc_mtx_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int COEF_W = 32,
  parameter int FRAC_W = 17,
  parameter int PRE_W  = 17
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [PRE_W-1:0]  pre  [NCOMP],
  input  logic signed [COEF_W-1:0] coef [NCOMP],
  input  logic [COEF_W/2-1:0]      cst,
  input  logic                     byp,
  input  logic [PIX_W-1:0]         byp_pix,
  output logic [PIX_W-1:0]         res
);
  localparam int HALF   = COEF_W / 2;
  localparam int PROD_W = PRE_W + COEF_W;
  localparam int ACC_W  = PROD_W + 3;
  localparam logic signed [ACC_W-1:0] RND  = {{(ACC_W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] MAXV = {{(ACC_W-PIX_W){1'b0}}, {PIX_W{1'b1}}};

  // stage 1: products
  logic signed [PROD_W-1:0] pa [NCOMP];
  logic signed [PROD_W-1:0] ca [NCOMP];
  logic signed [PROD_W-1:0] prod_q [NCOMP];
  logic [HALF-1:0]          cst_q;

  always_comb begin
    for (int j = 0; j < NCOMP; j++) begin
      pa[j] = $signed({{COEF_W{pre[j][PRE_W-1]}}, pre[j]});
      ca[j] = $signed({{PRE_W{coef[j][COEF_W-1]}}, coef[j]});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < NCOMP; j++) prod_q[j] <= '0;
      cst_q <= '0;
    end else begin
      for (int j = 0; j < NCOMP; j++) prod_q[j] <= pa[j] * ca[j];
      cst_q <= cst;
    end
  end

  // stage 2: sum, constant, rounding bias
  logic signed [ACC_W-1:0] sum_c;
  logic signed [ACC_W-1:0] cst_x;
  logic signed [ACC_W-1:0] acc_q;

  always_comb begin
    cst_x = $signed({{(ACC_W-HALF-FRAC_W){cst_q[HALF-1]}}, cst_q, {FRAC_W{1'b0}}});
    sum_c = cst_x + RND;
    for (int j = 0; j < NCOMP; j++)
      sum_c = sum_c + $signed({{(ACC_W-PROD_W){prod_q[j][PROD_W-1]}}, prod_q[j]});
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= sum_c;
  end

  // stage 3: scale, clamp, bypass select
  logic signed [ACC_W-1:0] scaled;
  logic [PIX_W-1:0]        clp;

  always_comb begin
    scaled = acc_q >>> FRAC_W;
    if (scaled < 0)         clp = '0;
    else if (scaled > MAXV) clp = '1;
    else                    clp = scaled[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) res <= '0;
    else     res <= byp ? byp_pix : clp;
  end
endmodule

// File: rtl/ycc_mtx_conv.sv
`timescale 1ns/1ps
module ycc_mtx_conv
  import ycc_mtx_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int COEF_W = 32,
  parameter int FRAC_W = 17,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_sel,
  input  logic [COEF_W-1:0] cfg_data,
  input  logic              frame_sof,
  input  logic              pix_in_vld,
  input  logic [PIX_W-1:0]  pix_in0,
  input  logic [PIX_W-1:0]  pix_in1,
  input  logic [PIX_W-1:0]  pix_in2,
  output logic              pix_out_vld,
  output logic [PIX_W-1:0]  pix_out0,
  output logic [PIX_W-1:0]  pix_out1,
  output logic [PIX_W-1:0]  pix_out2
);
  localparam int HALF  = COEF_W / 2;
  localparam int PRE_W = max2(PIX_W + 1, HALF) + 1;
  localparam int LAT   = 3;

  logic [NWORD-1:0][COEF_W-1:0] shd_w, act_w, eff_w;
  ctrl_t                        shd_ctrl, act_ctrl, eff_ctrl;

  ycc_mtx_regs #(.COEF_W(COEF_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .frame_sof(frame_sof), .shd_w(shd_w), .act_w(act_w),
    .shd_ctrl(shd_ctrl), .act_ctrl(act_ctrl)
  );

  // a frame-start pixel already sees the set being copied
  assign eff_w    = frame_sof ? shd_w    : act_w;
  assign eff_ctrl = frame_sof ? shd_ctrl : act_ctrl;

  logic [PIX_W-1:0]        pin [NCOMP];
  logic signed [PRE_W-1:0] pre [NCOMP];
  assign pin[0] = pix_in0;
  assign pin[1] = pix_in1;
  assign pin[2] = pix_in2;

  for (genvar j = 0; j < NCOMP; j++) begin : g_pre
    logic [HALF-1:0] dif;
    assign dif    = eff_w[WPR*j+NCOMP][COEF_W-1:HALF];
    assign pre[j] = $signed({{(PRE_W-PIX_W){1'b0}}, pin[j]}) +
                    $signed({{(PRE_W-HALF){dif[HALF-1]}}, dif});
  end

  // valid and bypass side pipe
  logic [LAT-1:0]               vld_q;
  logic                         en1_q, en2_q;
  logic [NCOMP-1:0][PIX_W-1:0]  raw1_q, raw2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      en1_q  <= 1'b0;
      en2_q  <= 1'b0;
      raw1_q <= '0;
      raw2_q <= '0;
    end else begin
      vld_q  <= {vld_q[LAT-2:0], pix_in_vld};
      en1_q  <= eff_ctrl.en;
      en2_q  <= en1_q;
      raw1_q <= {pix_in2, pix_in1, pix_in0};
      raw2_q <= raw1_q;
    end
  end

  logic [PIX_W-1:0] res [NCOMP];

  for (genvar k = 0; k < NCOMP; k++) begin : g_row
    logic signed [COEF_W-1:0] rc [NCOMP];
    assign rc[0] = eff_w[WPR*k];
    assign rc[1] = eff_ctrl.swap ? eff_w[WPR*k+2] : eff_w[WPR*k+1];
    assign rc[2] = eff_ctrl.swap ? eff_w[WPR*k+1] : eff_w[WPR*k+2];

    ycc_mtx_row #(.PIX_W(PIX_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .PRE_W(PRE_W)) u_row (
      .clk(clk), .rst(rst), .pre(pre), .coef(rc),
      .cst(eff_w[WPR*k+NCOMP][HALF-1:0]),
      .byp(!en2_q), .byp_pix(raw2_q[k]), .res(res[k])
    );
  end

  assign pix_out_vld = vld_q[LAT-1];
  assign pix_out0    = res[0];
  assign pix_out1    = res[1];
  assign pix_out2    = res[2];
endmodule

// File: rtl/ycc_mtx_chk.sv
`timescale 1ns/1ps
module ycc_mtx_chk
  import ycc_mtx_pkg::*;
#(
  parameter int COEF_W = 32,
  parameter int ADDR_W = 4
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         pix_in_vld,
  input logic                         pix_out_vld,
  input logic                         frame_sof,
  input logic                         cfg_wr,
  input logic [ADDR_W-1:0]            cfg_sel,
  input logic [NWORD-1:0][COEF_W-1:0] shd_w,
  input logic [NWORD-1:0][COEF_W-1:0] act_w,
  input ctrl_t                        shd_ctrl,
  input ctrl_t                        act_ctrl
);
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= 2'd0;
    else if (since_rst != 3)  since_rst <= since_rst + 2'd1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !pix_out_vld);

  a_r7_valid_delay: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (pix_out_vld == $past(pix_in_vld, 3)));

  a_r8_hold_between: assert property (@(posedge clk) disable iff (rst)
    !frame_sof |=> ($stable(act_w) && $stable(act_ctrl)));

  a_r8_copy_on_sof: assert property (@(posedge clk) disable iff (rst)
    frame_sof |=> ((act_w == $past(shd_w)) && (act_ctrl == $past(shd_ctrl))));

  a_r9_spare_ignored: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && (cfg_sel > ADDR_W'(NWORD))) |=> ($stable(shd_w) && $stable(shd_ctrl)));
endmodule

bind ycc_mtx_conv ycc_mtx_chk #(.COEF_W(COEF_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .pix_in_vld(pix_in_vld), .pix_out_vld(pix_out_vld),
  .frame_sof(frame_sof), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
  .shd_w(shd_w), .act_w(act_w), .shd_ctrl(shd_ctrl), .act_ctrl(act_ctrl)
);

// File: tb/tb_ycc_mtx_conv.sv
`timescale 1ns/1ps
module tb_ycc_mtx_conv;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [31:0] cfg_data = '0;
  logic        frame_sof = 1'b0;
  logic        pix_in_vld = 1'b0;
  logic [9:0]  pix_in0 = '0, pix_in1 = '0, pix_in2 = '0;
  logic        pix_out_vld;
  logic [9:0]  pix_out0, pix_out1, pix_out2;

  always #2.5 clk = ~clk;

  ycc_mtx_conv dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .frame_sof(frame_sof), .pix_in_vld(pix_in_vld),
    .pix_in0(pix_in0), .pix_in1(pix_in1), .pix_in2(pix_in2),
    .pix_out_vld(pix_out_vld), .pix_out0(pix_out0), .pix_out1(pix_out1), .pix_out2(pix_out2)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit started = 0;
  bit done = 0;
  string cur_tag = "R2";

  logic [31:0] m_shd [12];
  logic [31:0] m_act [12];
  int          m_shc, m_acc;

  bit    ev [3];
  int    ex [3][3];
  string et [3];

  localparam logic [31:0] TBL [12] = '{
    32'h0002542A, 32'h00000000, 32'h0003312A, 32'hFFC00000,
    32'h0002542A, 32'hFFFF376B, 32'hFFFE5FC3, 32'hFE000000,
    32'h0002542A, 32'h000408D2, 32'h00000000, 32'hFE000000};

  task automatic model_px(input logic [31:0] w [12], input int ctl, input int a [3],
                          output int r [3], output string tag);
    longint acc, d [3], cf;
    int col;
    bit clp = 0;
    for (int j = 0; j < 3; j++) d[j] = longint'($signed(w[4*j+3][31:16]));
    for (int k = 0; k < 3; k++) begin
      acc = longint'($signed(w[4*k+3][15:0])) * 131072 + 65536;
      for (int j = 0; j < 3; j++) begin
        col = j;
        if (ctl[1] && j == 1) col = 2;
        else if (ctl[1] && j == 2) col = 1;
        cf = longint'($signed(w[4*k+col]));
        acc = acc + cf * (a[j] + d[j]);
      end
      acc = acc >>> 17;
      if (acc < 0) begin r[k] = 0; clp = 1; end
      else if (acc > 1023) begin r[k] = 1023; clp = 1; end
      else r[k] = int'(acc);
      if (!ctl[0]) r[k] = a[k];
    end
    if (!ctl[0]) tag = "R6";
    else if (clp) tag = "R3";
    else if (ctl[1]) tag = "R5";
    else tag = "R2";
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    logic [31:0] ew [12];
    int ec, a [3], r [3];
    string tg;
    started <= 1'b1;
    if (rst) begin
      for (int i = 0; i < 12; i++) begin m_shd[i] = '0; m_act[i] = '0; end
      m_shc = 0; m_acc = 0;
      for (int s = 0; s < 3; s++) ev[s] = 0;
    end else begin
      for (int i = 0; i < 12; i++) ew[i] = frame_sof ? m_shd[i] : m_act[i];
      ec = frame_sof ? m_shc : m_acc;
      a[0] = int'(pix_in0); a[1] = int'(pix_in1); a[2] = int'(pix_in2);
      model_px(ew, ec, a, r, tg);
      for (int s = 2; s > 0; s--) begin
        ev[s] = ev[s-1]; et[s] = et[s-1];
        for (int k = 0; k < 3; k++) ex[s][k] = ex[s-1][k];
      end
      ev[0] = pix_in_vld;
      et[0] = {tg, "/", cur_tag};
      for (int k = 0; k < 3; k++) ex[0][k] = r[k];
      if (frame_sof) begin
        for (int i = 0; i < 12; i++) m_act[i] = m_shd[i];
        m_acc = m_shc;
      end
      if (cfg_wr) begin
        if (cfg_sel < 12) m_shd[cfg_sel] = cfg_data;
        else if (cfg_sel == 12) m_shc = int'(cfg_data[1:0]);
      end
    end
  end

  // comparison away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      n_chk++;
      if (pix_out_vld !== ev[2]) begin
        n_bad++;
        $display("FAIL R7 valid: actual %0b expected %0b at %0t", pix_out_vld, ev[2], $time);
      end else if (ev[2] && (pix_out0 !== 10'(ex[2][0]) || pix_out1 !== 10'(ex[2][1]) ||
                             pix_out2 !== 10'(ex[2][2]))) begin
        n_bad++;
        $display("FAIL %s pixel: actual %0d,%0d,%0d expected %0d,%0d,%0d at %0t", et[2],
                 pix_out0, pix_out1, pix_out2, ex[2][0], ex[2][1], ex[2][2], $time);
      end
    end
  end

  task automatic cyc(input bit v, input int a, input int b, input int c,
                     input bit wr, input int sel, input logic [31:0] dat, input bit sof);
    pix_in_vld = v; pix_in0 = 10'(a); pix_in1 = 10'(b); pix_in2 = 10'(c);
    cfg_wr = wr; cfg_sel = 4'(sel); cfg_data = dat; frame_sof = sof;
    @(negedge clk);
  endtask

  task automatic px(input int a, input int b, input int c);
    cyc(1, a, b, c, 0, 0, 0, 0);
  endtask

  task automatic rnd_px(input int n);
    for (int i = 0; i < n; i++) px($urandom_range(1023), $urandom_range(1023), $urandom_range(1023));
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (pix_out_vld !== 1'b0 || pix_out0 !== 10'd0) begin
      n_bad++;
      $display("FAIL R1 reset: actual vld %0b out0 %0d expected 0 0", pix_out_vld, pix_out0);
    end
    rst = 1'b0;

    // R6 pass-through while loading the shadow set (R8: not yet active)
    cur_tag = "R8";
    for (int i = 0; i < 12; i++)
      cyc(1, $urandom_range(1023), $urandom_range(1023), $urandom_range(1023), 1, i, TBL[i], 0);
    cyc(1, 100, 200, 300, 1, 12, 32'h1, 0);
    px(5, 6, 7);
    // frame start with a pixel: new set applies to it
    cyc(1, 64, 512, 512, 0, 0, 0, 1);
    cur_tag = "R2";
    px(940, 512, 512); px(64, 512, 512); px(502, 400, 600); px(300, 700, 350);
    cur_tag = "R3";
    rnd_px(200);

    // R5 swap, with a write coinciding with the frame start (R8)
    cyc(0, 0, 0, 0, 1, 12, 32'h3, 0);
    cur_tag = "R8";
    cyc(1, 400, 300, 700, 1, 1, 32'h00010000, 1);
    cur_tag = "R5";
    px(400, 700, 300); rnd_px(100);
    cur_tag = "R8";
    cyc(1, 400, 300, 700, 0, 0, 0, 1);
    rnd_px(20);

    // R4 offsets and post-add constants
    cur_tag = "R4";
    cyc(1, 10, 20, 30, 1, 3, 32'hFFC00010, 0);
    cyc(1, 10, 20, 30, 1, 7, 32'hFE00FFF0, 0);
    cyc(1, 10, 20, 30, 1, 11, 32'h00400100, 0);
    cyc(1, 10, 20, 30, 1, 12, 32'h1, 0);
    cyc(1, 64, 512, 512, 0, 0, 0, 1);
    rnd_px(100);

    // R9 spare locations ignored
    cur_tag = "R9";
    cyc(1, 1, 2, 3, 1, 13, 32'hFFFFFFFF, 0);
    cyc(1, 1, 2, 3, 1, 14, 32'hFFFFFFFF, 0);
    cyc(1, 1, 2, 3, 1, 15, 32'hFFFFFFFE, 0);
    cyc(1, 1, 2, 3, 0, 0, 0, 1);
    rnd_px(50);

    // R6 disable mid-stream, swap without enable still passes through
    cur_tag = "R6";
    cyc(1, 9, 8, 7, 1, 12, 32'h2, 0);
    px(11, 22, 33);
    cyc(1, 44, 55, 66, 0, 0, 0, 1);
    rnd_px(50);

    // R7 random gaps, writes and frame starts
    cur_tag = "R7";
    for (int i = 0; i < 1500; i++)
      cyc($urandom_range(1), $urandom_range(1023), $urandom_range(1023), $urandom_range(1023),
          ($urandom_range(3) == 0), $urandom_range(15),
          ($urandom_range(1) == 0) ? TBL[$urandom_range(11)] : 32'($urandom),
          ($urandom_range(15) == 0));
    repeat (6) cyc(0, 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #100us;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL R7 watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end
endmodule